// File: doc/BRIEF.md
# NOR Cell Program and Erase Engine

This block holds a small byte array that behaves like NOR flash cells and carries out the array-side work of a serial flash command sequencer. The sequencer passes it a request opcode, a start address and a data byte. It also supplies the current write-enable latch, a mask of supported erase sizes and a mode bit that makes the array behave like EEPROM. The engine programs single bytes, streams further bytes to consecutive addresses, erases aligned regions of several sizes and serves byte reads through a registered read port.

A program request writes one byte and leaves an internal cursor one address past it. Each following data strobe writes at the cursor and then moves it on. Erase requests align their address down to the erase size. They then write 0xFF one byte per clock while `busy` is high. Each completed request gives a one-cycle `done` pulse, and any protocol error flag is raised in that same cycle.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset every array byte reads 0xFF, and `busy`, `done`, `err_nowe` and `err_cap` are low.
- R2: With `eeprom_mode` low, a program stores the old byte ANDed with the new one, so bits can only go from 1 to 0.
- R3: With `eeprom_mode` high, a program stores the new byte unchanged and overwrites the old one.
- R4: Opcode 0x02 writes `req_data` at `req_addr`. Each later `data_valid` strobe with `req_valid` low writes `req_data` at the next address. The address wraps from the last byte to 0. `done` pulses in the cycle after each write is accepted.
- R5: A program or a data strobe with `wr_enable` low still writes the byte, and it raises `err_nowe` together with `done`.
- R6: Opcodes 0x20 and 0x21 erase SMALL_BYTES, 0x52 erases MID_BYTES, 0xD8 and 0xDC erase SECTOR_BYTES, and 0xC7 erases the whole array. The start address is aligned down to the erase size. Every byte in the region becomes 0xFF and all other bytes are left unchanged.
- R7: An accepted erase holds `busy` high for exactly as many cycles as it has bytes. `done` pulses in the first cycle in which `busy` is low again.
- R8: An erase requested with `wr_enable` low is rejected. `done` and `err_nowe` pulse in the next cycle, `busy` stays low and the array is unchanged.
- R9: An erase of the small size with `cap_mask[0]` clear, or of the mid size with `cap_mask[1]` clear, still runs in full and raises `err_cap` with its `done`. Sector and whole-array erases never raise `err_cap`.
- R10: While `busy` is high, `req_valid` and `data_valid` are ignored.
- R11: A request with any opcode not listed in R4 and R6 produces no `done`, no `busy` and no change to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 8 | Request opcode |
| req_addr | input | ADDR_W | Request start address |
| req_data | input | 8 | Byte to program |
| data_valid | input | 1 | Next sequential program byte (in `req_data`) |
| wr_enable | input | 1 | Current state of the write-enable latch |
| eeprom_mode | input | 1 | Program overwrites instead of ANDing |
| cap_mask | input | 2 | Bit 0: small erase supported; bit 1: mid erase supported |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Byte at `rd_addr`, one cycle later |
| busy | output | 1 | Erase walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err_nowe | output | 1 | Write-enable violation, with `done` |
| err_cap | output | 1 | Erase size not in `cap_mask`, with `done` |

## Verification
The bench uses the default build: a 512-byte array with 16-byte small, 64-byte mid and 128-byte sector erases. At these sizes every byte can be programmed, re-programmed and read back in a few thousand cycles. Each erase kind is started from an unaligned address and the full array is compared against a bench model afterwards. The cursor wrap at the top address, stray requests during a walk and every combination of cap bits and write enable are all exercised.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

   typedef enum logic [1:0] {
      OPK_NONE  = 2'd0,
      OPK_PROG  = 2'd1,
      OPK_ERASE = 2'd2
   } op_kind_e;

   localparam logic [7:0] OP_PROG      = 8'h02;
   localparam logic [7:0] OP_ERS_SMALL = 8'h20;
   localparam logic [7:0] OP_ERS_SMALL4= 8'h21;
   localparam logic [7:0] OP_ERS_MID   = 8'h52;
   localparam logic [7:0] OP_ERS_SECT  = 8'hD8;
   localparam logic [7:0] OP_ERS_SECT4 = 8'hDC;
   localparam logic [7:0] OP_ERS_ALL   = 8'hC7;

   localparam logic [7:0] ERASED_BYTE  = 8'hFF;

   typedef struct packed {
      op_kind_e kind;
      logic     need_small;
      logic     need_mid;
   } op_info_t;

endpackage

// File: rtl/flash_pe_decode.sv
module flash_pe_decode
   import flash_pe_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int SMALL_BYTES = 16,
   parameter int MID_BYTES   = 64,
   parameter int SECT_BYTES  = 128
) (
   input  logic [7:0]        op,
   output op_info_t          info,
   output logic [ADDR_W-1:0] len_m1
);

   localparam logic [ADDR_W-1:0] SMALL_M1 = ADDR_W'(SMALL_BYTES - 1);
   localparam logic [ADDR_W-1:0] MID_M1   = ADDR_W'(MID_BYTES - 1);
   localparam logic [ADDR_W-1:0] SECT_M1  = ADDR_W'(SECT_BYTES - 1);
   localparam logic [ADDR_W-1:0] ALL_M1   = {ADDR_W{1'b1}};

   always_comb begin
      info.kind       = OPK_NONE;
      info.need_small = 1'b0;
      info.need_mid   = 1'b0;
      len_m1          = '0;
      unique case (op)
         OP_PROG: begin
            info.kind = OPK_PROG;
         end
         OP_ERS_SMALL, OP_ERS_SMALL4: begin
            info.kind       = OPK_ERASE;
            info.need_small = 1'b1;
            len_m1          = SMALL_M1;
         end
         OP_ERS_MID: begin
            info.kind     = OPK_ERASE;
            info.need_mid = 1'b1;
            len_m1        = MID_M1;
         end
         OP_ERS_SECT, OP_ERS_SECT4: begin
            info.kind = OPK_ERASE;
            len_m1    = SECT_M1;
         end
         OP_ERS_ALL: begin
            info.kind = OPK_ERASE;
            len_m1    = ALL_M1;
         end
         default: begin
            info.kind = OPK_NONE;
         end
      endcase
   end

endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array
   import flash_pe_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              wr_merge,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0][7:0] cells;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [7:0] cell_q;
      logic       hit;

      assign hit = wr_en && (wr_addr == ADDR_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cell_q <= ERASED_BYTE;
         end else if (hit) begin
            cell_q <= wr_merge ? (cell_q & wr_data) : wr_data;
         end
      end

      assign cells[g] = cell_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else begin
         rd_data <= cells[rd_addr];
      end
   end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
   import flash_pe_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic              data_valid,
   input  logic              wr_enable,
   input  logic              eeprom_mode,
   input  logic [1:0]        cap_mask,
   input  op_info_t          info,
   input  logic [ADDR_W-1:0] len_m1,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_data,
   output logic              mem_merge,
   output logic              busy,
   output logic              done,
   output logic              err_nowe,
   output logic              err_cap
);

   logic              busy_q;
   logic [ADDR_W-1:0] cursor_q;
   logic [ADDR_W-1:0] walk_ptr_q;
   logic [ADDR_W-1:0] walk_cnt_q;
   logic              cap_pend_q;

   logic start_prog;
   logic next_byte;
   logic start_erase;
   logic cap_miss;

   assign start_prog  = !busy_q && req_valid && (info.kind == OPK_PROG);
   assign next_byte   = !busy_q && !req_valid && data_valid;
   assign start_erase = !busy_q && req_valid && (info.kind == OPK_ERASE);
   assign cap_miss    = (info.need_small && !cap_mask[0]) ||
                        (info.need_mid   && !cap_mask[1]);

   always_comb begin
      mem_we    = 1'b0;
      mem_addr  = cursor_q;
      mem_data  = req_data;
      mem_merge = !eeprom_mode;
      if (busy_q) begin
         mem_we    = 1'b1;
         mem_addr  = walk_ptr_q;
         mem_data  = ERASED_BYTE;
         mem_merge = 1'b0;
      end else if (start_prog) begin
         mem_we   = 1'b1;
         mem_addr = req_addr;
      end else if (next_byte) begin
         mem_we   = 1'b1;
         mem_addr = cursor_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         cursor_q   <= '0;
         walk_ptr_q <= '0;
         walk_cnt_q <= '0;
         cap_pend_q <= 1'b0;
         done       <= 1'b0;
         err_nowe   <= 1'b0;
         err_cap    <= 1'b0;
      end else begin
         done     <= 1'b0;
         err_nowe <= 1'b0;
         err_cap  <= 1'b0;
         if (busy_q) begin
            walk_ptr_q <= walk_ptr_q + 1'b1;
            walk_cnt_q <= walk_cnt_q - 1'b1;
            if (walk_cnt_q == '0) begin
               busy_q  <= 1'b0;
               done    <= 1'b1;
               err_cap <= cap_pend_q;
            end
         end else if (start_prog || next_byte) begin
            cursor_q <= mem_addr + 1'b1;
            done     <= 1'b1;
            err_nowe <= !wr_enable;
         end else if (start_erase) begin
            if (!wr_enable) begin
               done     <= 1'b1;
               err_nowe <= 1'b1;
            end else begin
               busy_q     <= 1'b1;
               walk_ptr_q <= req_addr & ~len_m1;
               walk_cnt_q <= len_m1;
               cap_pend_q <= cap_miss;
            end
         end
      end
   end

   assign busy = busy_q;

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
   import flash_pe_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int SMALL_BYTES = 16,
   parameter int MID_BYTES   = 64,
   parameter int SECT_BYTES  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [7:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic              data_valid,
   input  logic              wr_enable,
   input  logic              eeprom_mode,
   input  logic [1:0]        cap_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              done,
   output logic              err_nowe,
   output logic              err_cap
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr_w
      $error("flash_pe_engine: ADDR_W out of range");
   end
   if (SMALL_BYTES < 1 || (SMALL_BYTES & (SMALL_BYTES - 1)) != 0 ||
       SMALL_BYTES > DEPTH) begin : g_bad_small
      $error("flash_pe_engine: SMALL_BYTES must be a power of two within the array");
   end
   if (MID_BYTES < SMALL_BYTES || (MID_BYTES & (MID_BYTES - 1)) != 0 ||
       MID_BYTES > DEPTH) begin : g_bad_mid
      $error("flash_pe_engine: MID_BYTES must be a power of two, at least SMALL_BYTES");
   end
   if (SECT_BYTES < 1 || (SECT_BYTES & (SECT_BYTES - 1)) != 0 ||
       SECT_BYTES > DEPTH) begin : g_bad_sect
      $error("flash_pe_engine: SECT_BYTES must be a power of two within the array");
   end

   op_info_t          info;
   logic [ADDR_W-1:0] len_m1;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_data;
   logic              mem_merge;

   flash_pe_decode #(
      .ADDR_W      (ADDR_W),
      .SMALL_BYTES (SMALL_BYTES),
      .MID_BYTES   (MID_BYTES),
      .SECT_BYTES  (SECT_BYTES)
   ) decode_i (
      .op     (req_op),
      .info   (info),
      .len_m1 (len_m1)
   );

   flash_pe_ctrl #(
      .ADDR_W (ADDR_W)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_data    (req_data),
      .data_valid  (data_valid),
      .wr_enable   (wr_enable),
      .eeprom_mode (eeprom_mode),
      .cap_mask    (cap_mask),
      .info        (info),
      .len_m1      (len_m1),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_data    (mem_data),
      .mem_merge   (mem_merge),
      .busy        (busy),
      .done        (done),
      .err_nowe    (err_nowe),
      .err_cap     (err_cap)
   );

   flash_pe_array #(
      .ADDR_W (ADDR_W)
   ) array_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mem_we),
      .wr_addr  (mem_addr),
      .wr_data  (mem_data),
      .wr_merge (mem_merge),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/flash_pe_engine_chk.sv
module flash_pe_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_enable,
   input logic busy,
   input logic done,
   input logic err_nowe,
   input logic err_cap
);

   AST_ERASE_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_enable)); // R8

   AST_DONE_AT_WALK_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R7

   AST_NOWE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_nowe |-> done); // R5

   AST_CAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_cap |-> (done && !busy)); // R9

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy && !done)); // R1

   AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !done); // R10

endmodule

bind flash_pe_engine flash_pe_engine_chk chk_i (.*);

// File: tb/flash_pe_engine_tb_top.sv
module flash_pe_engine_tb_top;

   localparam int ADDR_W = 9;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int SMALL  = 16;
   localparam int MID    = 64;
   localparam int SECT   = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [7:0]        req_op = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [7:0]        req_data = '0;
   logic              data_valid = 1'b0;
   logic              wr_enable = 1'b1;
   logic              eeprom_mode = 1'b0;
   logic [1:0]        cap_mask = 2'b11;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        rd_data;
   logic              busy, done, err_nowe, err_cap;

   logic [7:0] model [DEPTH];
   int checks = 0;
   int errors = 0;
   int cursor = 0;

   always #2 clk = ~clk;

   flash_pe_engine #(
      .ADDR_W(ADDR_W), .SMALL_BYTES(SMALL), .MID_BYTES(MID), .SECT_BYTES(SECT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .data_valid(data_valid),
      .wr_enable(wr_enable), .eeprom_mode(eeprom_mode), .cap_mask(cap_mask),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
      .err_nowe(err_nowe), .err_cap(err_cap)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic read_all(input string tag);
      int bad = 0;
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = ADDR_W'(a);
         tick();
         if (rd_data !== model[a]) begin
            if (bad == 0)
               $display("FAIL %s: addr 0x%0h actual 0x%0h expected 0x%0h",
                        tag, a, rd_data, model[a]);
            bad++;
         end
      end
      checks++;
      if (bad != 0) errors++;
   endtask

   task automatic apply_prog(input int a, input logic [7:0] d);
      if (eeprom_mode) model[a] = d;
      else             model[a] = model[a] & d;
   endtask

   task automatic prog(input int a, input logic [7:0] d, input string tag);
      req_valid = 1'b1; req_op = 8'h02; req_addr = ADDR_W'(a); req_data = d;
      tick();
      req_valid = 1'b0;
      apply_prog(a, d);
      cursor = (a + 1) % DEPTH;
      chk(done === 1'b1 && err_nowe === !wr_enable, tag,
          {done, err_nowe}, {1'b1, !wr_enable});
   endtask

   task automatic next_byte(input logic [7:0] d, input string tag);
      data_valid = 1'b1; req_data = d;
      tick();
      data_valid = 1'b0;
      apply_prog(cursor, d);
      cursor = (cursor + 1) % DEPTH;
      chk(done === 1'b1 && err_nowe === !wr_enable, tag,
          {done, err_nowe}, {1'b1, !wr_enable});
   endtask

   task automatic erase(input logic [7:0] op, input int a, input int len,
                        input bit exp_cap, input bit inject, input string tag);
      int n = 0;
      int base;
      req_valid = 1'b1; req_op = op; req_addr = ADDR_W'(a);
      tick();
      req_valid = 1'b0;
      if (!wr_enable) begin
         chk(busy === 1'b0 && done === 1'b1 && err_nowe === 1'b1, tag,
             {busy, done, err_nowe}, 3'b011);
         return;
      end
      while (busy === 1'b1 && n < 5000) begin
         if (inject && n == 2) begin
            // R10: stray program and data strobe into the walk
            req_valid = 1'b1; req_op = 8'h02; req_addr = ADDR_W'((a + 300) % DEPTH);
            req_data = 8'h00;
         end else if (inject && n == 3) begin
            req_valid = 1'b0; data_valid = 1'b1;
         end else begin
            req_valid = 1'b0; data_valid = 1'b0;
         end
         n++;
         tick();
      end
      req_valid = 1'b0; data_valid = 1'b0;
      chk(n == len, {tag, " busy length"}, n, len);
      chk(done === 1'b1 && err_cap === exp_cap && err_nowe === 1'b0,
          {tag, " done/err_cap"}, {done, err_cap, err_nowe}, {1'b1, exp_cap, 1'b0});
      base = a - (a % len);
      for (int i = 0; i < len; i++) model[base + i] = 8'hFF;
   endtask

   task automatic fill(input int seed);
      for (int a = 0; a < DEPTH; a++) begin
         eeprom_mode = 1'b1;
         prog(a, 8'((a * seed + 3) & 8'hFF), "R3 refill");
      end
      eeprom_mode = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(busy === 0 && done === 0 && err_nowe === 0 && err_cap === 0, "R1 outputs",
          {busy, done, err_nowe, err_cap}, 0);
      read_all("R1 array erased");

      // R2 + R4: program sweep with single requests, AND semantics
      for (int a = 0; a < DEPTH; a++) prog(a, 8'((a * 37 + 11) & 8'hFF), "R4 program");
      read_all("R2 first pass");
      // R4: streamed second pass, AND over existing data
      prog(0, 8'h5A, "R4 stream start");
      for (int a = 1; a < DEPTH; a++) next_byte(8'((a * 91 + 5) & 8'hFF), "R4 stream");
      read_all("R2 AND pass");

      // R3: EEPROM overwrite raises bits back
      eeprom_mode = 1'b1;
      prog(40, 8'hC3, "R3 program");
      for (int a = 41; a < 72; a++) next_byte(8'(a ^ 8'hA5), "R3 stream");
      eeprom_mode = 1'b0;
      read_all("R3 overwrite");

      // R4: cursor wrap from top address to 0
      eeprom_mode = 1'b1;
      prog(DEPTH - 2, 8'h11, "R4 wrap start");
      next_byte(8'h22, "R4 wrap");
      next_byte(8'h33, "R4 wrap to zero");
      eeprom_mode = 1'b0;
      read_all("R4 wrap contents");

      // R5: program without write enable still writes
      wr_enable = 1'b0;
      prog(100, 8'h0F, "R5 program no WE");
      next_byte(8'hF0, "R5 stream no WE");
      wr_enable = 1'b1;
      read_all("R5 contents");

      // R8: rejected erase
      wr_enable = 1'b0;
      erase(8'hC7, 0, DEPTH, 1'b0, 1'b0, "R8 chip erase no WE");
      erase(8'h20, 5, SMALL, 1'b0, 1'b0, "R8 small erase no WE");
      wr_enable = 1'b1;
      read_all("R8 array unchanged");

      // R11: unknown opcode
      req_valid = 1'b1; req_op = 8'h55; req_addr = 9'd7; req_data = 8'h00;
      tick();
      req_valid = 1'b0;
      chk(done === 0 && busy === 0, "R11 no done", {done, busy}, 0);
      read_all("R11 array unchanged");

      // R6 + R7: each erase kind from an unaligned address
      erase(8'h20, 8'h23, SMALL, 1'b0, 1'b0, "R6 small 0x20");
      read_all("R6 after 0x20");
      erase(8'h21, DEPTH - 1, SMALL, 1'b0, 1'b0, "R6 small 0x21");
      read_all("R6 after 0x21");
      erase(8'h52, 8'h85, MID, 1'b0, 1'b1, "R6 mid 0x52");
      read_all("R10 after mid with stray requests");
      erase(8'hD8, 9'h17F, SECT, 1'b0, 1'b0, "R6 sector 0xD8");
      read_all("R6 after 0xD8");
      fill(13);
      erase(8'hDC, 0, SECT, 1'b0, 1'b0, "R6 sector 0xDC");
      read_all("R6 after 0xDC");

      // R9: missing capability bits
      cap_mask = 2'b01;
      erase(8'h52, 9'h1C9, MID, 1'b1, 1'b0, "R9 mid without cap");
      cap_mask = 2'b10;
      erase(8'h21, 9'h0A7, SMALL, 1'b1, 1'b0, "R9 small without cap");
      cap_mask = 2'b00;
      erase(8'hD8, 9'h0C0, SECT, 1'b0, 1'b0, "R9 sector needs no cap");
      read_all("R9 erases still done");
      cap_mask = 2'b11;

      // R6: whole array
      fill(29);
      erase(8'hC7, 9'h1AB, DEPTH, 1'b0, 1'b1, "R6 chip erase");
      read_all("R6 after chip erase");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule